// File: doc/BRIEF.md
# Spill-Locked Multi-Event Buffer

This block is the front-end event store of a beam experiment that runs in accelerator cycles. While a cycle is open, a digitizer writes event records into it. Each record is a run of data words framed by a start marker and an end marker. One cycle may contain several spills (for example two short spills of a few events and one long spill of several tens of events), or a calibration sequence with no beam. The store keeps collecting across all of them and is not cleared between spills.

A single end-of-cycle strobe seals the store. Once sealed, and only while the spill input is low, a read-start strobe sends the whole content out as one burst. The burst is one word per clock, in write order, with first-word and last-word flags for each event. The event count and word count stay visible on the ports for the whole burst. When the burst finishes, a done pulse marks it and the store is emptied for the next cycle. If the spill returns during a burst, the burst is abandoned and an error flag is raised. The data stay in place so that they can be read again later.

A hard limit applies both to the number of events and to the number of words. Event starts that arrive after either limit is reached are discarded and counted.

Top module: `spill_evt_buffer`

## Requirements
- R1: While reset is applied, every output is zero: no valid word, no done pulse, no error, not sealed, not reading, not full, and all counters at zero.
- R2: A write with `wr_sop_i`=1 opens an event and stores its word. The following words with `wr_sop_i`=0 are stored until a word with `wr_eop_i`=1 (stored as well) closes the event. Words arriving outside an open event are ignored. `evt_cnt_o` and `word_cnt_o` show the number of events and words stored so far.
- R3: When `MAX_EVT` events are stored, `full_o` is 1. Each further event start is discarded together with its body words and adds one to `ovf_cnt_o`, which saturates at its all-ones value.
- R4: An event start that finds `DEPTH` words already stored counts as a discarded start (as in R3). Body words of an open event that arrive when `DEPTH` words are stored are dropped, and the event's end marker still closes it.
- R5: Before `cyc_end_i` is seen, spills may start and stop any number of times without clearing the store. A `cyc_end_i` pulse while no burst is running sets `sealed_o`. From the next clock on, writes are ignored until the burst completes.
- R6: `rd_start_i` starts a burst only when `sealed_o`=1, `spill_i`=0 and no burst is running. In any other case it has no effect and `reading_o` stays 0.
- R7: In the cycle after an accepted start, the burst begins to present one stored word per cycle with `rd_vld_o`=1, in write order. `rd_sop_o` marks the first word of each event and `rd_eop_o` marks its last word.
- R8: In the cycle after the last word, `rd_done_o` pulses for one cycle. At the same time both counts, the overflow count and `sealed_o` return to zero. A burst over an empty sealed store gives the done pulse in the cycle after the start.
- R9: If `spill_i` is 1 while a burst is running, `rd_vld_o` is 0 from the next cycle on, the burst ends without a done pulse, and `proto_err_o` is set. The error stays set until the next accepted start. The store stays sealed with its content intact, and a new burst starts again from the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spill_i | input | 1 | Beam spill level |
| cyc_end_i | input | 1 | End-of-cycle strobe, seals the store |
| wr_vld_i | input | 1 | Write word valid |
| wr_sop_i | input | 1 | Write word is the first of an event |
| wr_eop_i | input | 1 | Write word is the last of an event |
| wr_data_i | input | DATA_W | Write data word |
| rd_start_i | input | 1 | Burst read start strobe |
| rd_vld_o | output | 1 | Burst word valid |
| rd_sop_o | output | 1 | Burst word is the first of an event |
| rd_eop_o | output | 1 | Burst word is the last of an event |
| rd_data_o | output | DATA_W | Burst data word |
| rd_done_o | output | 1 | One-cycle pulse at the end of a complete burst |
| evt_cnt_o | output | clog2(MAX_EVT+1) | Events stored |
| word_cnt_o | output | clog2(DEPTH+1) | Words stored |
| full_o | output | 1 | Event limit reached |
| ovf_cnt_o | output | OVF_W | Discarded event starts, saturating |
| sealed_o | output | 1 | Cycle closed, writes locked |
| reading_o | output | 1 | Burst in progress |
| proto_err_o | output | 1 | Spill seen during a burst |

## Verification
The assertions assume that the strobes `cyc_end_i` and `rd_start_i` are single-cycle pulses. They also assume that `spill_i` is a clean level, synchronous to `clk`, and that the write markers are meaningful only while `wr_vld_i` is 1. The bench drives every input on the falling edge and holds it for exactly one period. Strobes are cleared in the following period, and spill changes only between bursts, except for the deliberate abort case. A small event limit and depth in the bench let the full, overflow, truncation and abort corners be reached in a few hundred cycles.

// File: rtl/evb_pkg.sv
package evb_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_RUN  = 1'b1
  } rd_st_e;
endpackage

// File: rtl/evb_store.sv
module evb_store #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 512,
  parameter int MAX_EVT = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = $clog2(MAX_EVT)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              bwe,
  input  logic [IW-1:0]     bidx,
  input  logic [AW-1:0]     bval,
  input  logic [IW-1:0]     bridx,
  output logic [AW-1:0]     brval
);
  // word array and per-event start-address table
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     bnd_q [MAX_EVT];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (bwe) bnd_q[bidx] <= bval;
  end

  assign rdata = mem_q[raddr];
  assign brval = bnd_q[bridx];
endmodule

// File: rtl/evb_wr_frame.sv
module evb_wr_frame #(
  parameter int MAX_EVT = 256,
  parameter int DEPTH   = 512,
  parameter int OVF_W   = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = $clog2(MAX_EVT),
  localparam int EW = $clog2(MAX_EVT + 1),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             wr_vld,
  input  logic             wr_sop,
  input  logic             wr_eop,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic             bnd_we,
  output logic [IW-1:0]    bnd_idx,
  output logic [AW-1:0]    bnd_val,
  output logic [EW-1:0]    evt_cnt,
  output logic [CW-1:0]    word_cnt,
  output logic [OVF_W-1:0] ovf_cnt
);
  logic             in_evt_q, in_evt_d;
  logic [EW-1:0]    evt_q, evt_d;
  logic [CW-1:0]    wc_q, wc_d;
  logic [OVF_W-1:0] ovf_q, ovf_d;
  logic             room_evt, room_wrd, sop_hit, sop_ok, sop_drop, body_ok, store;

  assign room_evt = evt_q < EW'(MAX_EVT);
  assign room_wrd = wc_q < CW'(DEPTH);
  assign sop_hit  = wr_vld & en & wr_sop;
  assign sop_ok   = sop_hit & room_evt & room_wrd;
  assign sop_drop = sop_hit & ~sop_ok;
  assign body_ok  = wr_vld & en & ~wr_sop & in_evt_q & room_wrd;
  assign store    = sop_ok | body_ok;

  always_comb begin
    in_evt_d = in_evt_q;
    evt_d    = evt_q;
    wc_d     = wc_q;
    ovf_d    = ovf_q;
    if (clr) begin
      in_evt_d = 1'b0;
      evt_d    = '0;
      wc_d     = '0;
      ovf_d    = '0;
    end else begin
      if (wr_vld && en) begin
        if (wr_sop)      in_evt_d = sop_ok & ~wr_eop;
        else if (wr_eop) in_evt_d = 1'b0;
      end
      if (store)  wc_d  = wc_q + CW'(1);
      if (sop_ok) evt_d = evt_q + EW'(1);
      if (sop_drop && (ovf_q != '1)) ovf_d = ovf_q + OVF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_evt_q <= 1'b0;
      evt_q    <= '0;
      wc_q     <= '0;
      ovf_q    <= '0;
    end else begin
      in_evt_q <= in_evt_d;
      evt_q    <= evt_d;
      wc_q     <= wc_d;
      ovf_q    <= ovf_d;
    end
  end

  assign mem_we    = store;
  assign mem_waddr = wc_q[AW-1:0];
  assign bnd_we    = sop_ok;
  assign bnd_idx   = evt_q[IW-1:0];
  assign bnd_val   = wc_q[AW-1:0];
  assign evt_cnt   = evt_q;
  assign word_cnt  = wc_q;
  assign ovf_cnt   = ovf_q;

  AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_hit && !room_evt) |=> (evt_q == $past(evt_q))); // R3
  AST_WORD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && in_evt_q && !room_wrd && !clr) |=> (wc_q == $past(wc_q))); // R4
  AST_LOCKED_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(wc_q) && $stable(evt_q))); // R5
endmodule

// File: rtl/evb_rd_ctrl.sv
module evb_rd_ctrl
  import evb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MAX_EVT = 256,
  parameter int DEPTH   = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = $clog2(MAX_EVT),
  localparam int EW = $clog2(MAX_EVT + 1),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spill_i,
  input  logic              cyc_end_i,
  input  logic              rd_start_i,
  input  logic [EW-1:0]     evt_cnt,
  input  logic [CW-1:0]     wcnt,
  output logic [AW-1:0]     mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IW-1:0]     bnd_ridx,
  input  logic [AW-1:0]     bnd_rval,
  output logic              rd_vld_o,
  output logic              rd_sop_o,
  output logic              rd_eop_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_done_o,
  output logic              clr_o,
  output logic              sealed_o,
  output logic              reading_o,
  output logic              err_o
);
  rd_st_e            st_q, st_d;
  logic [CW-1:0]     rptr_q, rptr_d, nxt_start;
  logic [EW-1:0]     rev_q, rev_d, rev_nx;
  logic              pend_q, pend_d, seal_q, seal_d, err_q, err_d;
  logic              vld_q, vld_d, sop_q, sop_d, eop_q, eop_d, done_q, done_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              last_w, at_end, start_ok, abort, finish, emit;

  assign rev_nx    = rev_q + EW'(1);
  assign bnd_ridx  = rev_nx[IW-1:0];
  assign nxt_start = (rev_nx < evt_cnt) ? CW'(bnd_rval) : wcnt;
  assign mem_raddr = rptr_q[AW-1:0];
  assign last_w    = (rptr_q + CW'(1)) == nxt_start;
  assign at_end    = rptr_q == wcnt;
  assign start_ok  = (st_q == RD_IDLE) & rd_start_i & ~spill_i & seal_q;
  assign abort     = (st_q == RD_RUN) & spill_i;
  assign finish    = (st_q == RD_RUN) & ~spill_i & at_end;
  assign emit      = (st_q == RD_RUN) & ~spill_i & ~at_end;

  always_comb begin
    st_d   = st_q;
    rptr_d = rptr_q;
    rev_d  = rev_q;
    pend_d = pend_q;
    seal_d = seal_q;
    err_d  = err_q;
    vld_d  = 1'b0;
    sop_d  = 1'b0;
    eop_d  = 1'b0;
    done_d = 1'b0;
    data_d = data_q;
    if (start_ok) begin
      st_d   = RD_RUN;
      rptr_d = '0;
      rev_d  = '0;
      pend_d = 1'b1;
      err_d  = 1'b0;
    end else if ((st_q == RD_IDLE) && cyc_end_i) begin
      seal_d = 1'b1;
    end
    if (abort) begin
      st_d   = RD_IDLE;
      err_d  = 1'b1;
      rptr_d = '0;
      rev_d  = '0;
    end
    if (finish) begin
      st_d   = RD_IDLE;
      done_d = 1'b1;
      seal_d = 1'b0;
      rptr_d = '0;
      rev_d  = '0;
    end
    if (emit) begin
      vld_d  = 1'b1;
      data_d = mem_rdata;
      sop_d  = pend_q;
      eop_d  = last_w;
      rptr_d = rptr_q + CW'(1);
      pend_d = last_w;
      if (last_w) rev_d = rev_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      rptr_q <= '0;
      rev_q  <= '0;
      pend_q <= 1'b0;
      seal_q <= 1'b0;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      rptr_q <= rptr_d;
      rev_q  <= rev_d;
      pend_q <= pend_d;
      seal_q <= seal_d;
      err_q  <= err_d;
      vld_q  <= vld_d;
      sop_q  <= sop_d;
      eop_q  <= eop_d;
      done_q <= done_d;
      data_q <= data_d;
    end
  end

  assign rd_vld_o  = vld_q;
  assign rd_sop_o  = sop_q;
  assign rd_eop_o  = eop_q;
  assign rd_data_o = data_q;
  assign rd_done_o = done_q;
  assign clr_o     = finish;
  assign sealed_o  = seal_q;
  assign reading_o = st_q == RD_RUN;
  assign err_o     = err_q;

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == RD_IDLE) && (spill_i || !seal_q)) |=> (st_q == RD_IDLE)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done_o |=> !rd_done_o); // R8
  AST_SPILL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == RD_RUN) && spill_i) |=> (!rd_vld_o && !rd_done_o && err_o && seal_q)); // R9
endmodule

// File: rtl/spill_evt_buffer.sv
module spill_evt_buffer #(
  parameter int DATA_W  = 16,
  parameter int MAX_EVT = 256,
  parameter int DEPTH   = 512,
  parameter int OVF_W   = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = $clog2(MAX_EVT),
  localparam int EW = $clog2(MAX_EVT + 1),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spill_i,
  input  logic              cyc_end_i,
  input  logic              wr_vld_i,
  input  logic              wr_sop_i,
  input  logic              wr_eop_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_start_i,
  output logic              rd_vld_o,
  output logic              rd_sop_o,
  output logic              rd_eop_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_done_o,
  output logic [EW-1:0]     evt_cnt_o,
  output logic [CW-1:0]     word_cnt_o,
  output logic              full_o,
  output logic [OVF_W-1:0]  ovf_cnt_o,
  output logic              sealed_o,
  output logic              reading_o,
  output logic              proto_err_o
);
  logic              rs0_q, rs1_q, srst_n;
  logic              mem_we, bnd_we, clr;
  logic [AW-1:0]     mem_waddr, mem_raddr, bnd_val, bnd_rval;
  logic [IW-1:0]     bnd_idx, bnd_ridx;
  logic [DATA_W-1:0] mem_rdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign srst_n = rs1_q;

  evb_wr_frame #(.MAX_EVT(MAX_EVT), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_wr (
    .clk(clk), .rst_n(srst_n), .en(~sealed_o), .clr(clr),
    .wr_vld(wr_vld_i), .wr_sop(wr_sop_i), .wr_eop(wr_eop_i),
    .mem_we(mem_we), .mem_waddr(mem_waddr),
    .bnd_we(bnd_we), .bnd_idx(bnd_idx), .bnd_val(bnd_val),
    .evt_cnt(evt_cnt_o), .word_cnt(word_cnt_o), .ovf_cnt(ovf_cnt_o)
  );

  evb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_EVT(MAX_EVT)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data_i),
    .raddr(mem_raddr), .rdata(mem_rdata),
    .bwe(bnd_we), .bidx(bnd_idx), .bval(bnd_val),
    .bridx(bnd_ridx), .brval(bnd_rval)
  );

  evb_rd_ctrl #(.DATA_W(DATA_W), .MAX_EVT(MAX_EVT), .DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(srst_n), .spill_i(spill_i), .cyc_end_i(cyc_end_i),
    .rd_start_i(rd_start_i), .evt_cnt(evt_cnt_o), .wcnt(word_cnt_o),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .bnd_ridx(bnd_ridx), .bnd_rval(bnd_rval),
    .rd_vld_o(rd_vld_o), .rd_sop_o(rd_sop_o), .rd_eop_o(rd_eop_o),
    .rd_data_o(rd_data_o), .rd_done_o(rd_done_o), .clr_o(clr),
    .sealed_o(sealed_o), .reading_o(reading_o), .err_o(proto_err_o)
  );

  assign full_o = evt_cnt_o == EW'(MAX_EVT);

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!srst_n)
    rd_done_o |-> ((evt_cnt_o == '0) && (word_cnt_o == '0) && !sealed_o && (ovf_cnt_o == '0))); // R8
  AST_EVT_BOUND: assert property (@(posedge clk) disable iff (!srst_n)
    (evt_cnt_o <= EW'(MAX_EVT))); // R3
  AST_NO_OUTPUT_IN_SPILL: assert property (@(posedge clk) disable iff (!srst_n)
    spill_i |=> !rd_vld_o); // R6
endmodule

// File: tb/sim_spill_evt_buffer.sv
module sim_spill_evt_buffer;
  localparam int PERIOD = 10;
  localparam int DW = 16;
  localparam int MAXE = 8;
  localparam int DEP = 24;
  localparam int OW = 8;

  logic clk, rst_n, spill, cyc_end, wr_vld, wr_sop, wr_eop, rd_start;
  logic [DW-1:0] wr_data;
  logic rd_vld, rd_sop, rd_eop, rd_done, full, sealed, reading, perr;
  logic [DW-1:0] rd_data;
  logic [3:0] evt_cnt;
  logic [4:0] word_cnt;
  logic [OW-1:0] ovf_cnt;

  int vecs = 0, errs = 0;
  bit cmp_en = 0;

  spill_evt_buffer #(.DATA_W(DW), .MAX_EVT(MAXE), .DEPTH(DEP), .OVF_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .spill_i(spill), .cyc_end_i(cyc_end),
    .wr_vld_i(wr_vld), .wr_sop_i(wr_sop), .wr_eop_i(wr_eop), .wr_data_i(wr_data),
    .rd_start_i(rd_start), .rd_vld_o(rd_vld), .rd_sop_o(rd_sop), .rd_eop_o(rd_eop),
    .rd_data_o(rd_data), .rd_done_o(rd_done), .evt_cnt_o(evt_cnt), .word_cnt_o(word_cnt),
    .full_o(full), .ovf_cnt_o(ovf_cnt), .sealed_o(sealed), .reading_o(reading),
    .proto_err_o(perr)
  );

  initial clk = 0;
  always #(PERIOD/2) clk = ~clk;

  // behavioural reference model
  int mq[$];
  int ms[$];
  bit m_in, m_seal, m_rd, m_err, m_vld, m_sop, m_eop, m_done;
  int m_ovf, m_rptr, m_data;

  function automatic bit is_start(int a);
    foreach (ms[i]) if (ms[i] == a) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); ms.delete();
      m_in = 0; m_seal = 0; m_rd = 0; m_err = 0; m_vld = 0; m_done = 0;
      m_sop = 0; m_eop = 0; m_ovf = 0; m_rptr = 0;
    end else begin
      m_vld = 0; m_done = 0; m_sop = 0; m_eop = 0;
      if (!m_seal && wr_vld) begin
        if (wr_sop) begin
          if (ms.size() < MAXE && mq.size() < DEP) begin
            ms.push_back(mq.size()); mq.push_back(int'(wr_data)); m_in = !wr_eop;
          end else begin
            if (m_ovf < 255) m_ovf++;
            m_in = 0;
          end
        end else if (m_in) begin
          if (mq.size() < DEP) mq.push_back(int'(wr_data));
          if (wr_eop) m_in = 0;
        end
      end
      if (m_rd) begin
        if (spill) begin
          m_rd = 0; m_err = 1; m_rptr = 0;
        end else if (m_rptr == mq.size()) begin
          m_rd = 0; m_done = 1; m_seal = 0; m_rptr = 0;
          mq.delete(); ms.delete(); m_ovf = 0; m_in = 0;
        end else begin
          m_vld = 1; m_data = mq[m_rptr]; m_sop = is_start(m_rptr);
          m_eop = (m_rptr + 1 == mq.size()) || is_start(m_rptr + 1);
          m_rptr++;
        end
      end else if (rd_start && !spill && m_seal) begin
        m_rd = 1; m_rptr = 0; m_err = 0;
      end else if (cyc_end) begin
        m_seal = 1;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2", "evt_cnt", int'(evt_cnt), ms.size());
      chk("R2", "word_cnt", int'(word_cnt), mq.size());
      chk("R3", "full", int'(full), int'(ms.size() == MAXE));
      chk("R3", "ovf_cnt", int'(ovf_cnt), m_ovf);
      chk("R5", "sealed", int'(sealed), int'(m_seal));
      chk("R6", "reading", int'(reading), int'(m_rd));
      chk("R7", "rd_vld", int'(rd_vld), int'(m_vld));
      if (m_vld) begin
        chk("R7", "rd_data", int'(rd_data), m_data);
        chk("R7", "rd_sop", int'(rd_sop), int'(m_sop));
        chk("R7", "rd_eop", int'(rd_eop), int'(m_eop));
      end
      chk("R8", "rd_done", int'(rd_done), int'(m_done));
      chk("R9", "proto_err", int'(perr), int'(m_err));
    end
  end

  task automatic drv(bit v, bit s, bit e, int d, bit ce, bit rs);
    @(negedge clk);
    wr_vld = v; wr_sop = s; wr_eop = e; wr_data = DW'(d);
    cyc_end = ce; rd_start = rs;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, 0);
  endtask

  task automatic send_evt(int n, int base);
    for (int i = 0; i < n; i++) drv(1, i == 0, i == n - 1, base + i, 0, 0);
  endtask

  task automatic read_all();
    drv(0, 0, 0, 0, 0, 1);
    idle(1);
    for (int i = 0; i < 100 && m_rd; i++) idle(1);
    idle(2);
  endtask

  initial begin
    #(PERIOD * 100000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 0; spill = 0; cyc_end = 0; wr_vld = 0; wr_sop = 0; wr_eop = 0;
    wr_data = '0; rd_start = 0;
    repeat (3) @(negedge clk);
    // R1: reset state of every output
    chk("R1", "rd_vld", int'(rd_vld), 0);
    chk("R1", "rd_done", int'(rd_done), 0);
    chk("R1", "counts", int'(evt_cnt) + int'(word_cnt) + int'(ovf_cnt), 0);
    chk("R1", "flags", int'(full) + int'(sealed) + int'(reading) + int'(perr), 0);
    rst_n = 1;
    idle(3);
    cmp_en = 1;

    // R2 R5: two spills plus off-spill stray words, no clearing between spills
    spill = 1; send_evt(1, 16'h100); send_evt(3, 16'h110); send_evt(2, 16'h120); idle(1);
    spill = 0; drv(1, 0, 0, 16'h1ff, 0, 0); drv(1, 0, 1, 16'h1fe, 0, 0);
    drv(0, 0, 0, 0, 0, 1); idle(2);             // R6: start while unsealed is ignored
    spill = 1; send_evt(4, 16'h130); send_evt(1, 16'h140); idle(1);
    spill = 0; idle(1);
    drv(0, 0, 0, 0, 1, 0); idle(1);             // R5: seal
    send_evt(2, 16'h150); idle(1);              // R5: ignored after seal
    spill = 1; drv(0, 0, 0, 0, 0, 1); idle(2);  // R6: start during spill ignored
    spill = 0; idle(1);
    read_all();                                 // R7 R8

    // R3: calibration cycle beyond the event limit
    for (int k = 0; k < MAXE + 2; k++) send_evt(1 + (k % 2), 16'h200 + 4 * k);
    idle(1);
    drv(0, 0, 0, 0, 1, 0); idle(1);
    read_all();

    // R4: word capacity, truncation and start refused for lack of words
    send_evt(10, 16'h300); send_evt(10, 16'h310); send_evt(10, 16'h320);
    send_evt(2, 16'h330); idle(1);
    drv(0, 0, 0, 0, 1, 0); idle(1);
    read_all();

    // R9: spill during a burst aborts it, then a full re-read
    send_evt(2, 16'h400); send_evt(3, 16'h410); send_evt(2, 16'h420); idle(1);
    drv(0, 0, 0, 0, 1, 0); idle(1);
    drv(0, 0, 0, 0, 0, 1); idle(3);
    spill = 1; idle(3);
    spill = 0; idle(1);
    read_all();

    // R8: empty sealed store
    drv(0, 0, 0, 0, 1, 0); idle(1);
    read_all();

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule